// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Styles

This block gives software sixteen general-purpose pins behind a small word-addressed register port. Software drives a pin by writing the output-data word and clearing that line's bit in the direction word. Setting the bit (the reset value) turns the line into an input and releases its driver. Each incoming pin passes through a two-flop synchroniser, and the synchronised levels can be read back at any time.

Every line also has its own interrupt detector. A 3-bit style code picks one of five triggers: high level, low level, rising edge, falling edge, or any transition. The three remaining codes switch detection off. A detected event latches into a sticky status bit. That bit drives the line's request to the interrupt controller as an active-high level. Software clears status bits by writing ones. If a level-style line is still at its active level, its bit sets again on the next cycle. Two further words, a clock-output control word and a debounce-select word, are only stored here and presented on output ports for neighbouring logic.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is applied and just after release, every register reads zero except the direction word at byte offset 0x04, which reads 0x0000FFFF. The pin driver enables and all interrupt requests are zero.
- R2: Offset 0x00 holds the output data and offset 0x04 the direction bits, both read back in bits 15:0. pin_out follows the output data. pin_drive_en[i] is high exactly when direction bit i is 0; a 1 means the line is an input.
- R3: Offset 0x08 returns the pins after a two-flop synchroniser, so a pin change is visible on the second rising edge after it is applied. Writes to this offset change nothing.
- R4: Offset 0x10 holds the styles of lines 0 to 7 and offset 0x14 those of lines 8 to 15. The field for line i sits at bits 3*(i mod 8)+2 : 3*(i mod 8). Bits 31:24 of both words read as zero.
- R5: Style 0 sets the status bit on every cycle the synchronised input is 1. Style 1 sets it on every cycle the input is 0.
- R6: Edge styles compare the synchronised input with its value one cycle earlier. Style 2 sets status on 0-to-1, style 3 on 1-to-0, and style 4 on either change. A steady input never sets status.
- R7: Style codes 5, 6 and 7 never set the status bit, whatever the pin does.
- R8: A write to offset 0x0C clears each status bit whose data bit is 1. Bits written as 0 keep their state.
- R9: A cleared level-style bit sets again on the following edge while the input is still active. It stays clear only after the input has gone inactive.
- R10: When a detected event and a write-one clear of the same bit fall on the same clock edge, the bit ends up set.
- R11: irq_out[i] is high exactly when status bit i is set. Status reads back at offset 0x0C, bits 15:0.
- R12: Offsets 0x18 and 0x1C store full 32-bit words that read back and drive clk_cfg and dbnc_cfg. Offsets of 0x20 and above, and any address with bits 1:0 non-zero, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr | input | 8 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data toward the pads |
| pin_drive_en | output | 16 | Per-line pad driver enable |
| irq_out | output | 16 | Per-line active-high interrupt requests |
| clk_cfg | output | 32 | Stored clock-output control word |
| dbnc_cfg | output | 32 | Stored debounce-select word |

## Verification
The bench times a write-one clear so that it lands on exactly the edge where a rising-edge event reaches status. A design where the clear wins would drop that request and lose the edge for good. It clears a level-low line while the pin is still low: a design that treats levels as edges would leave the request low, and one that ignores clears would never let it fall after the pin returns high. It also drives the three disabled codes against toggling pins, and writes to the read-only input word, to misaligned addresses and to unmapped addresses. A wrong decode would raise requests or corrupt stored words there. The bank split is covered too: a line-8 field that landed in the low style word would show up as a request on the wrong line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned STYLE_W = 3;

  typedef logic [STYLE_W-1:0] style_t;

  // trigger codes
  localparam style_t STY_LVL_HI = 3'd0;
  localparam style_t STY_LVL_LO = 3'd1;
  localparam style_t STY_RISE   = 3'd2;
  localparam style_t STY_FALL   = 3'd3;
  localparam style_t STY_ANY    = 3'd4;

  // word indices (byte offset / 4)
  localparam int unsigned WIDX_DOUT = 0;
  localparam int unsigned WIDX_DIR  = 1;
  localparam int unsigned WIDX_DIN  = 2;
  localparam int unsigned WIDX_STAT = 3;
  localparam int unsigned WIDX_STLO = 4;
  localparam int unsigned WIDX_STHI = 5;
  localparam int unsigned WIDX_CLKC = 6;
  localparam int unsigned WIDX_DBNC = 7;
  localparam int unsigned NUM_WORDS = 8;

  function automatic logic style_hit(input style_t sty, input logic cur, input logic prev);
    case (sty)
      STY_LVL_HI: return cur;
      STY_LVL_LO: return !cur;
      STY_RISE:   return cur & !prev;
      STY_FALL:   return !cur & prev;
      STY_ANY:    return cur ^ prev;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] sync_q,
  output logic [N-1:0] sync_prev
);

  logic [N-1:0] meta_q, meta_d;
  logic [N-1:0] sync_d, prev_d;
  logic [N-1:0] sync_r, prev_r;

  always_comb begin
    meta_d = pin_in;
    sync_d = meta_q;
    prev_d = sync_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_r <= '0;
      prev_r <= '0;
    end else begin
      meta_q <= meta_d;
      sync_r <= sync_d;
      prev_r <= prev_d;
    end
  end

  assign sync_q    = sync_r;
  assign sync_prev = prev_r;

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N*STYLE_W-1:0] style_flat,
  input  logic [N-1:0]         cur,
  input  logic [N-1:0]         prev,
  output logic [N-1:0]         evt
);

  for (genvar i = 0; i < N; i++) begin : g_line
    style_t sty;
    assign sty    = style_flat[i*STYLE_W +: STYLE_W];
    assign evt[i] = style_hit(sty, cur[i], prev[i]);

    // R7: codes beyond the defined set stay silent
    a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (sty > STY_ANY) |-> !evt[i]);

    // R6: an edge style only fires when the sampled level moved
    a_r6_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      ((sty >= STY_RISE) && (sty <= STY_ANY) && evt[i]) |-> (cur[i] != prev[i]));
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] status
);

  logic [N-1:0] stat_q, stat_d, clr_eff;

  always_comb begin
    clr_eff = clr_we ? clr_mask : '0;
    stat_d  = (stat_q & ~clr_eff) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;

  // R10: every detected event is latched, even against a clear
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

  // R8: a written one without a competing event clears the bit
  a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((stat_q & $past(clr_mask & ~evt)) == '0));

  // R8: no bit becomes set without an event
  a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N              = 16,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned LINES_PER_BANK = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [N-1:0]         sync_in,
  input  logic [N-1:0]         status,
  output logic [N-1:0]         dout,
  output logic [N-1:0]         dir,
  output logic [N*STYLE_W-1:0] style_flat,
  output logic [DATA_W-1:0]    clkc,
  output logic [DATA_W-1:0]    dbnc,
  output logic                 clr_we,
  output logic [N-1:0]         clr_mask
);

  localparam int unsigned BANK_W = LINES_PER_BANK * STYLE_W;
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned FLAT_W = N * STYLE_W;

  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic [N-1:0]      dout_q, dout_d, dir_q, dir_d;
  logic [BANK_W-1:0] stlo_q, stlo_d, sthi_q, sthi_d;
  logic [DATA_W-1:0] clkc_q, clkc_d, dbnc_q, dbnc_d;
  logic [2*BANK_W-1:0] sty_all;

  assign idx = reg_addr[ADDR_W-1:2];
  assign hit = (reg_addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_WORDS));

  // next state
  always_comb begin
    dout_d = dout_q;
    dir_d  = dir_q;
    stlo_d = stlo_q;
    sthi_d = sthi_q;
    clkc_d = clkc_q;
    dbnc_d = dbnc_q;
    if (reg_we && hit) begin
      case (idx)
        IDX_W'(WIDX_DOUT): dout_d = reg_wdata[N-1:0];
        IDX_W'(WIDX_DIR):  dir_d  = reg_wdata[N-1:0];
        IDX_W'(WIDX_STLO): stlo_d = reg_wdata[BANK_W-1:0];
        IDX_W'(WIDX_STHI): sthi_d = reg_wdata[BANK_W-1:0];
        IDX_W'(WIDX_CLKC): clkc_d = reg_wdata;
        IDX_W'(WIDX_DBNC): dbnc_d = reg_wdata;
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '1;
      stlo_q <= '0;
      sthi_q <= '0;
      clkc_q <= '0;
      dbnc_q <= '0;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
      stlo_q <= stlo_d;
      sthi_q <= sthi_d;
      clkc_q <= clkc_d;
      dbnc_q <= dbnc_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      case (idx)
        IDX_W'(WIDX_DOUT): reg_rdata = DATA_W'(dout_q);
        IDX_W'(WIDX_DIR):  reg_rdata = DATA_W'(dir_q);
        IDX_W'(WIDX_DIN):  reg_rdata = DATA_W'(sync_in);
        IDX_W'(WIDX_STAT): reg_rdata = DATA_W'(status);
        IDX_W'(WIDX_STLO): reg_rdata = DATA_W'(stlo_q);
        IDX_W'(WIDX_STHI): reg_rdata = DATA_W'(sthi_q);
        IDX_W'(WIDX_CLKC): reg_rdata = clkc_q;
        IDX_W'(WIDX_DBNC): reg_rdata = dbnc_q;
        default:           reg_rdata = '0;
      endcase
    end
  end

  assign sty_all    = {sthi_q, stlo_q};
  assign style_flat = sty_all[FLAT_W-1:0];
  assign dout       = dout_q;
  assign dir        = dir_q;
  assign clkc       = clkc_q;
  assign dbnc       = dbnc_q;
  assign clr_we     = reg_we && hit && (idx == IDX_W'(WIDX_STAT));
  assign clr_mask   = reg_wdata[N-1:0];

  // R12: stored words only move on a decoded write
  a_r12_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && hit) |=> ($stable(clkc_q) && $stable(dbnc_q) && $stable(dout_q) && $stable(dir_q)));

  // R3: a write to the input word leaves every stored word alone
  a_r3_din_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && hit && idx == IDX_W'(WIDX_DIN)) |=> ($stable(stlo_q) && $stable(sthi_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N              = 16,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned LINES_PER_BANK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_drive_en,
  output logic [N-1:0]      irq_out,
  output logic [DATA_W-1:0] clk_cfg,
  output logic [DATA_W-1:0] dbnc_cfg
);

  logic rs_meta_q, rs_done_q, rst_i_n;
  logic [N-1:0] sync_cur, sync_prev, evt, status, dout, dir, clr_mask;
  logic [N*STYLE_W-1:0] style_flat;
  logic clr_we;

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_done_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_done_q <= rs_meta_q;
    end
  end
  assign rst_i_n = rs_done_q;

  gpio_in_sync #(.N(N)) u_sync (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .pin_in    (pin_in),
    .sync_q    (sync_cur),
    .sync_prev (sync_prev)
  );

  gpio_evt_detect #(.N(N)) u_evt (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .style_flat (style_flat),
    .cur        (sync_cur),
    .prev       (sync_prev),
    .evt        (evt)
  );

  gpio_irq_status #(.N(N)) u_stat (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .evt      (evt),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .status   (status)
  );

  gpio_regfile #(
    .N              (N),
    .DATA_W         (DATA_W),
    .ADDR_W         (ADDR_W),
    .LINES_PER_BANK (LINES_PER_BANK)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .sync_in    (sync_cur),
    .status     (status),
    .dout       (dout),
    .dir        (dir),
    .style_flat (style_flat),
    .clkc       (clk_cfg),
    .dbnc       (dbnc_cfg),
    .clr_we     (clr_we),
    .clr_mask   (clr_mask)
  );

  assign pin_out      = dout;
  assign pin_drive_en = ~dir;
  assign irq_out      = status;

  // R11: a raised request always has a pending status behind it
  a_r11_irq_tracks_status: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|(evt & ~status)) |=> ((irq_out & $past(evt)) == $past(evt)));

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

  logic        clk, rst_n, reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, clk_cfg, dbnc_cfg;
  logic [15:0] pins, pin_out, pin_drive_en, irq_out;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, chk_on = 0;

  gpio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pins),
    .pin_out(pin_out), .pin_drive_en(pin_drive_en), .irq_out(irq_out),
    .clk_cfg(clk_cfg), .dbnc_cfg(dbnc_cfg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  bit [15:0] m_dout, m_dir, m_stat, m_s1, m_s2, m_s3;
  bit [23:0] m_st0, m_st1;
  bit [31:0] m_clk, m_dbn;
  int m_rcnt;

  function automatic void m_reset();
    m_dout = 0; m_dir = 16'hFFFF; m_stat = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    m_st0 = 0; m_st1 = 0; m_clk = 0; m_dbn = 0;
  endfunction

  function automatic bit m_hit(input logic [7:0] a);
    return (a[1:0] == 2'b00) && (a < 8'h20);
  endfunction

  function automatic int m_style(input int ln);
    if (ln < 8) return int'(m_st0[3*ln +: 3]);
    return int'(m_st1[3*(ln-8) +: 3]);
  endfunction

  function automatic logic [31:0] m_rdata(input logic [7:0] a);
    if (!m_hit(a)) return 32'h0;
    case (a)
      8'h00: return {16'h0, m_dout};
      8'h04: return {16'h0, m_dir};
      8'h08: return {16'h0, m_s2};
      8'h0C: return {16'h0, m_stat};
      8'h10: return {8'h0, m_st0};
      8'h14: return {8'h0, m_st1};
      8'h18: return m_clk;
      default: return m_dbn;
    endcase
  endfunction

  initial m_reset();

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_rcnt = 0; m_reset();
    end else if (m_rcnt < 2) begin
      m_rcnt++; m_reset();
    end else begin
      bit [15:0] ev, clr;
      for (int i = 0; i < 16; i++) begin
        case (m_style(i))
          0: ev[i] = m_s2[i];
          1: ev[i] = !m_s2[i];
          2: ev[i] = m_s2[i] && !m_s3[i];
          3: ev[i] = !m_s2[i] && m_s3[i];
          4: ev[i] = m_s2[i] != m_s3[i];
          default: ev[i] = 1'b0;
        endcase
      end
      clr = (reg_we && reg_addr == 8'h0C) ? reg_wdata[15:0] : 16'h0;
      m_stat = (m_stat & ~clr) | ev;
      if (reg_we && m_hit(reg_addr)) begin
        case (reg_addr)
          8'h00: m_dout = reg_wdata[15:0];
          8'h04: m_dir  = reg_wdata[15:0];
          8'h10: m_st0  = reg_wdata[23:0];
          8'h14: m_st1  = reg_wdata[23:0];
          8'h18: m_clk  = reg_wdata;
          8'h1C: m_dbn  = reg_wdata;
          default: ;
        endcase
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(input logic [7:0] a);
    if (!m_hit(a)) return "R12";
    case (a)
      8'h00, 8'h04: return "R2";
      8'h08: return "R3";
      8'h0C: return "R8";
      8'h10, 8'h14: return "R4";
      default: return "R12";
    endcase
  endfunction

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk(pin_out === m_dout, "R2 pin_out", {16'h0, pin_out}, {16'h0, m_dout});
      chk(pin_drive_en === ~m_dir, "R2 drive_en", {16'h0, pin_drive_en}, {16'h0, ~m_dir});
      chk(irq_out === m_stat, "R11 irq_out", {16'h0, irq_out}, {16'h0, m_stat});
      chk(reg_rdata === m_rdata(reg_addr), rd_tag(reg_addr), reg_rdata, m_rdata(reg_addr));
      chk(clk_cfg === m_clk && dbnc_cfg === m_dbn, "R12 cfg", clk_cfg ^ dbnc_cfg, m_clk ^ m_dbn);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pins(input logic [15:0] p);
    @(posedge clk); #2;
    pins = p;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    finish_run();
  end

  // ---------------- directed and random sequence ----------------
  initial begin
    logic [31:0] v, st_lo, st_hi;
    rst_n = 1'b1; reg_we = 1'b0; reg_addr = 8'h00; reg_wdata = 32'h0; pins = 16'h0;
    #1 rst_n = 1'b0;
    #2 chk_on = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk(irq_out === 16'h0, "R1 irq", {16'h0, irq_out}, 32'h0);
    chk(pin_drive_en === 16'h0, "R1 drive_en", {16'h0, pin_drive_en}, 32'h0);
    @(posedge clk); #2 rst_n = 1'b1;
    rd(8'h04, v);
    chk(v === 32'h0000FFFF, "R1 dir reset", v, 32'h0000FFFF);
    rd(8'h00, v);
    chk(v === 32'h0, "R1 dout reset", v, 32'h0);
    settle(3);

    // R7: park every line on a disabled code, then toggle pins
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v);
    chk(v === 32'h00FF_FFFF, "R4 upper bits zero", v, 32'h00FF_FFFF);
    st_hi = 0;
    for (int i = 0; i < 8; i++) st_hi |= 32'(5 + (i % 3)) << (3*i);
    wr(8'h14, st_hi);
    for (int k = 0; k < 6; k++) begin
      set_pins(16'hFFFF ^ pins);
      settle(2);
    end
    chk(irq_out === 16'h0, "R7 disabled codes", {16'h0, irq_out}, 32'h0);

    // R2: output data and direction
    wr(8'h00, 32'h0000_A5C3);
    wr(8'h04, 32'h0000_00FF);
    settle(1);
    chk(pin_out === 16'hA5C3, "R2 pin_out", {16'h0, pin_out}, 32'hA5C3);
    chk(pin_drive_en === 16'hFF00, "R2 drive_en", {16'h0, pin_drive_en}, 32'hFF00);

    // R3: synchronised input, write ignored
    set_pins(16'h1234);
    settle(2);
    rd(8'h08, v);
    chk(v === 32'h1234, "R3 input word", v, 32'h1234);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v);
    chk(v === 32'h1234, "R3 write ignored", v, 32'h1234);

    // per-line styles: l0 rise, l1 fall, l2 any, l3 level-high, l4 level-low, l5..7 off
    set_pins(16'h0010);
    st_lo = 32'(2) | (32'(3) << 3) | (32'(4) << 6) | (32'(0) << 9) | (32'(1) << 12)
          | (32'(7) << 15) | (32'(7) << 18) | (32'(7) << 21);
    wr(8'h10, st_lo);
    settle(3);
    wr(8'h0C, 32'hFFFF);
    settle(1);
    chk(irq_out === 16'h0, "R8 clear all", {16'h0, irq_out}, 32'h0);

    // R9: level-low re-sets while active, clears once inactive
    set_pins(16'h0000);
    settle(4);
    chk(irq_out[4] === 1'b1, "R5 level-low set", {31'h0, irq_out[4]}, 32'h1);
    wr(8'h0C, 32'h0010);
    settle(1);
    chk(irq_out[4] === 1'b1, "R9 re-set while active", {31'h0, irq_out[4]}, 32'h1);
    set_pins(16'h0010);
    settle(4);
    wr(8'h0C, 32'h0010);
    settle(1);
    chk(irq_out[4] === 1'b0, "R9 clear once inactive", {31'h0, irq_out[4]}, 32'h0);

    // R5: level-high
    set_pins(16'h0018);
    settle(4);
    wr(8'h0C, 32'h0008);
    settle(1);
    chk(irq_out[3] === 1'b1, "R5 level-high held", {31'h0, irq_out[3]}, 32'h1);
    set_pins(16'h0010);
    settle(4);
    wr(8'h0C, 32'h0008);
    settle(1);
    chk(irq_out[3] === 1'b0, "R5 level-high cleared", {31'h0, irq_out[3]}, 32'h0);

    // R6: falling on line 1
    set_pins(16'h0012);
    settle(4);
    chk(irq_out[1] === 1'b0, "R6 falling ignores rise", {31'h0, irq_out[1]}, 32'h0);
    set_pins(16'h0010);
    settle(4);
    chk(irq_out[1] === 1'b1, "R6 falling edge", {31'h0, irq_out[1]}, 32'h1);

    // R6: any transition on line 2, both directions
    wr(8'h0C, 32'hFFFF);
    set_pins(16'h0014);
    settle(4);
    chk(irq_out[2] === 1'b1, "R6 any rise", {31'h0, irq_out[2]}, 32'h1);
    wr(8'h0C, 32'h0004);
    set_pins(16'h0010);
    settle(4);
    chk(irq_out[2] === 1'b1, "R6 any fall", {31'h0, irq_out[2]}, 32'h1);

    // R8: selective clear; line 0 rising plus line 2 pending
    set_pins(16'h0011);
    settle(4);
    wr(8'h0C, 32'h0001);
    settle(1);
    chk(irq_out[2:0] === 3'b100, "R8 only ones clear", {29'h0, irq_out[2:0]}, 32'h4);
    wr(8'h0C, 32'h0000);
    settle(1);
    chk(irq_out[2] === 1'b1, "R8 zero no effect", {31'h0, irq_out[2]}, 32'h1);
    chk(irq_out[0] === 1'b0, "R6 steady high no event", {31'h0, irq_out[0]}, 32'h0);

    // R10: clear lands on the edge that latches a rising event on line 0
    set_pins(16'h0010);
    settle(4);
    wr(8'h0C, 32'hFFFF);
    @(posedge clk); #2 pins = 16'h0011;
    @(posedge clk); @(posedge clk); #2;
    reg_we = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h0001;
    @(posedge clk); #2 reg_we = 1'b0;
    @(negedge clk);
    chk(irq_out[0] === 1'b1, "R10 event beats clear", {31'h0, irq_out[0]}, 32'h1);

    // R11 / R4: upper bank, level-high on all lines 8..15
    wr(8'h14, 32'h0);
    set_pins(16'h8110);
    settle(4);
    chk(irq_out[15:8] === 8'h81, "R11 upper bank irq", {24'h0, irq_out[15:8]}, 32'h81);
    rd(8'h0C, v);
    chk(v[15:8] === 8'h81, "R11 status readback", {24'h0, v[15:8]}, 32'h81);

    // R12: stored words, unmapped and misaligned
    wr(8'h18, 32'hDEAD_BEEF);
    wr(8'h1C, 32'h1234_5678);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h1A, 32'h0);
    settle(1);
    chk(clk_cfg === 32'hDEAD_BEEF, "R12 clk_cfg", clk_cfg, 32'hDEAD_BEEF);
    chk(dbnc_cfg === 32'h1234_5678, "R12 dbnc_cfg", dbnc_cfg, 32'h1234_5678);
    rd(8'h20, v);
    chk(v === 32'h0, "R12 unmapped reads zero", v, 32'h0);
    rd(8'h19, v);
    chk(v === 32'h0, "R12 misaligned reads zero", v, 32'h0);

    // random traffic, compared against the reference every cycle
    for (int k = 0; k < 1500; k++) begin
      @(posedge clk); #2;
      pins      = 16'($urandom);
      reg_we    = ($urandom % 3) == 0;
      reg_addr  = 8'($urandom % 40);
      reg_wdata = $urandom;
    end
    @(posedge clk); #2 reg_we = 1'b0;
    settle(4);
    finish_run();
  end

endmodule